// File: doc/BRIEF.md
# Two-Wire 16-Bit Register Slave

This block is a slave on a two-wire serial bus. It lets a host read and write a bank of 32 registers that are each 16 bits wide. Any other device on the same wires, such as a byte-wide identification memory, answers at its own address, and this block ignores that traffic. The host addresses the block with a fixed 7-bit device address and a direction bit. On a write it then sends a pointer byte that picks the register. A read always uses the pointer left by the most recent write.

Every register access moves exactly two data bytes. The high byte goes first and bits go out most significant first. On the register side the block has a plain synchronous port. A single-cycle write strobe carries the pointer and the assembled 16-bit word. A single-cycle read strobe asks the register file for a word, which the file returns one clock later. SCL and SDA are synchronised and then glitch-filtered. SDA is driven only low, through an open-drain enable.

Top module: `twr16_slave`

## Requirements
- R1: While reset is held and straight after it is released, `sda_oe`, `reg_wr` and `reg_rd` are all 0.
- R2: An address byte whose upper seven bits are 1010110 is acknowledged. Any other address byte is not acknowledged, and every byte after it is ignored until the next START, with no acknowledge and no strobe.
- R3: The byte sequence address 0xAC, pointer, high data, low data gives one `reg_wr` pulse. The pulse has `reg_addr` equal to pointer bits [4:0] and `reg_wdata` equal to {high, low}. All four bytes are acknowledged, and the pulse comes only after the acknowledge of the low byte, while SCL is low.
- R4: A STOP after only one data byte of a write discards that byte, so no `reg_wr` occurs and the register keeps its value.
- R5: A repeated START followed by address 0xAD returns the selected register as two bytes, high byte first and MSB first. The master acknowledges the first byte and not the second.
- R6: Each read access gives exactly one single-cycle `reg_rd` pulse, with `reg_addr` equal to the current pointer.
- R7: A write that stops after the pointer byte sets the pointer for later reads and gives no `reg_wr`. This also holds when the read is a separate transaction that opens with a fresh START.
- R8: Data bytes after the second byte of a write are not acknowledged and cause no further `reg_wr`.
- R9: Pulses on SCL or SDA shorter than FILT clock cycles have no effect on a transfer.
- R10: `reg_wr` and `reg_rd` each last one cycle and are never high together. `sda_oe` changes only while SCL is low.
- R11: Bits [7:5] of the pointer byte are ignored, so 0xE3 selects register 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | PTR_W | Register pointer |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 16 | Word to write, high byte received first |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 16 | Word from the register file, valid one cycle after `reg_rd` |

## Verification
The bench attacks partial transactions. A write cut off by a STOP after one data byte must not commit, so a design that strobes early would corrupt the register. A write with a third data byte must stay at one commit, so a design that loops back to the high byte would write again. A foreign address must silence the block until the next START, and a design that only refuses the address byte would still acknowledge the data bytes after it. The bench also checks that a read taken over a fresh START still uses the stored pointer. It checks that strobe cycles are counted exactly, which catches a clear-on-read side effect fired twice. Short pulses are injected on both lines, and an unfiltered design would lose bits or see a false START.

// File: rtl/twr16_slave.sv
module twr16_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1010110,
  parameter int         PTR_W    = 5,
  parameter int         FILT     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic             reg_wr,
  output logic [15:0]      reg_wdata,
  output logic             reg_rd,
  input  logic [15:0]      reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;
  typedef enum logic [2:0] {B_ADDR, B_PTR, B_HI, B_LO, B_REST} bt_t;

  logic [1:0]      sy1, sy2, flt, flt_q;
  logic [FILT-1:0] hist [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1   <= '1;
      sy2   <= '1;
      flt   <= '1;
      flt_q <= '1;
      for (int k = 0; k < 2; k++) hist[k] <= '1;
    end else begin
      sy1   <= {scl_i, sda_i};
      sy2   <= sy1;
      flt_q <= flt;
      for (int k = 0; k < 2; k++) begin
        hist[k] <= {hist[k][FILT-2:0], sy2[k]};
        if (&hist[k])       flt[k] <= 1'b1;
        else if (~|hist[k]) flt[k] <= 1'b0;
      end
    end
  end

  wire sda_f    = flt[0];
  wire scl_rise = flt[1] & ~flt_q[1];
  wire scl_fall = ~flt[1] & flt_q[1];
  wire start_c  = flt[1] & flt_q[1] & flt_q[0] & ~flt[0];
  wire stop_c   = flt[1] & flt_q[1] & ~flt_q[0] & flt[0];

  st_t             st;
  bt_t             bt;
  logic [2:0]      cnt;
  logic [7:0]      sh, whi, wlo;
  logic            got, rnw, wr_go, rd_cap, mack;
  logic [PTR_W-1:0] ptr;
  logic [15:0]     rbuf;

  assign reg_addr  = ptr;
  assign reg_wdata = {whi, wlo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bt <= B_ADDR; cnt <= '0; sh <= '0; whi <= '0; wlo <= '0;
      got <= 1'b0; rnw <= 1'b0; wr_go <= 1'b0; rd_cap <= 1'b0; mack <= 1'b0;
      ptr <= '0; rbuf <= '0; sda_oe <= 1'b0; reg_wr <= 1'b0; reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      rd_cap <= reg_rd;
      if (rd_cap) rbuf <= reg_rdata;
      if (start_c) begin
        st <= S_RX; bt <= B_ADDR; cnt <= '0; got <= 1'b0; sda_oe <= 1'b0; wr_go <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; wr_go <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 3'd1;
              got <= (cnt == 3'd7);
            end else if (scl_fall && got) begin
              got <= 1'b0;
              st  <= S_RACK;
              case (bt)
                B_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    rnw    <= sh[0];
                    reg_rd <= sh[0];
                  end else begin
                    st <= S_IDLE;
                  end
                end
                B_PTR: begin sda_oe <= 1'b1; ptr <= sh[PTR_W-1:0]; end
                B_HI:  begin sda_oe <= 1'b1; whi <= sh; end
                B_LO:  begin sda_oe <= 1'b1; wlo <= sh; wr_go <= 1'b1; end
                default: ;
              endcase
            end
          end
          S_RACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (wr_go) begin reg_wr <= 1'b1; wr_go <= 1'b0; end
              if (bt == B_ADDR && rnw) begin
                st <= S_TX; bt <= B_HI; sh <= rbuf[15:8]; sda_oe <= ~rbuf[15];
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RX;
                case (bt)
                  B_ADDR:  bt <= B_PTR;
                  B_PTR:   bt <= B_HI;
                  B_HI:    bt <= B_LO;
                  default: bt <= B_REST;
                endcase
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                st <= S_TACK; sda_oe <= 1'b0;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
              end
            end
          end
          S_TACK: begin
            if (scl_rise) mack <= ~sda_f;
            else if (scl_fall) begin
              if (mack && bt == B_HI) begin
                st <= S_TX; bt <= B_LO; cnt <= '0; sh <= rbuf[7:0]; sda_oe <= ~rbuf[7];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twr16_slave_chk.sv
module twr16_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_wr,
  input logic reg_rd
);

  a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr);
  a_r6_rd_single:  assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd);
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd));
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
                                     (sda_oe != $past(sda_oe)) |-> !scl_i);
  a_r3_wr_scl_low: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> !scl_i);

endmodule

bind twr16_slave twr16_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/sim_twr16_slave.sv
module sim_twr16_slave;
  localparam int HP = 30;
  localparam int Q  = 10;
  localparam logic [7:0] DEVW = 8'hAC;
  localparam logic [7:0] DEVR = 8'hAD;
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 16'h1234}, {8'h1F, 16'hA5C3}, {8'h07, 16'h0000},
    {8'h10, 16'hFFFF}, {8'hE3, 16'h8001}, {8'h0C, 16'h7E81}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  bit   m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic sda_i;
  assign sda_i = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  twr16_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_i), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  logic [15:0] mem [32];
  int wr_cyc = 0, rd_cyc = 0, both_cyc = 0;
  logic [4:0]  last_wa, last_ra;
  logic [15:0] last_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= 16'h0100 + 16'(i);
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        wr_cyc <= wr_cyc + 1; last_wa <= reg_addr; last_wd <= reg_wdata;
        mem[reg_addr] <= reg_wdata;
      end
      if (reg_rd) begin
        rd_cyc <= rd_cyc + 1; last_ra <= reg_addr;
        reg_rdata <= mem[reg_addr];
      end
      if (reg_wr && reg_rd) both_cyc <= both_cyc + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    tick(Q); m_sda = 1'b1; tick(HP - Q); m_scl = 1'b1; tick(HP); m_sda = 1'b0; tick(HP); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    tick(Q); m_sda = 1'b0; tick(HP - Q); m_scl = 1'b1; tick(HP); m_sda = 1'b1; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit g, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_sda = b[i]; tick(8);
      if (g) begin m_scl = 1'b1; tick(2); m_scl = 1'b0; end else tick(2);
      tick(HP - Q - 10);
      m_scl = 1'b1; tick(10);
      if (g && b[i]) begin m_sda = 1'b0; tick(2); m_sda = 1'b1; end else tick(2);
      tick(HP - 12); m_scl = 1'b0;
    end
    tick(Q); m_sda = 1'b1; tick(HP - Q); m_scl = 1'b1; tick(HP / 2);
    ack = !sda_i;
    tick(HP / 2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(HP); m_scl = 1'b1; tick(HP / 2); b[i] = sda_i; tick(HP / 2); m_scl = 1'b0;
    end
    tick(Q); m_sda = !ack; tick(HP - Q); m_scl = 1'b1; tick(HP); m_scl = 1'b0;
    tick(Q); m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] p, input logic [15:0] d, input bit g, output bit ok);
    bit a0, a1, a2, a3;
    bus_start;
    send_byte(DEVW, g, a0); send_byte(p, g, a1);
    send_byte(d[15:8], g, a2); send_byte(d[7:0], g, a3);
    bus_stop;
    ok = a0 & a1 & a2 & a3;
  endtask

  task automatic do_read(input logic [7:0] p, output logic [15:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start;
    send_byte(DEVW, 1'b0, a0); send_byte(p, 1'b0, a1);
    bus_start;
    send_byte(DEVR, 1'b0, a2);
    recv_byte(1'b1, d[15:8]); recv_byte(1'b0, d[7:0]);
    bus_stop;
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ok, a;
    logic [15:0] d;
    int w0, r0;
    tick(3);
    chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R1 in reset", {sda_oe, reg_wr, reg_rd}, 0);
    tick(7); rst_n = 1'b1; tick(20);
    chk(sda_oe == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R1 after reset", {sda_oe, reg_wr, reg_rd}, 0);

    for (int v = 0; v < NV; v++) begin
      w0 = wr_cyc;
      do_write(VEC[v][23:16], VEC[v][15:0], 1'b0, ok);
      chk(ok, "R3 acks", ok, 1);
      // R11: only pointer bits [4:0] select the register
      chk(wr_cyc == w0 + 1 && last_wa == VEC[v][20:16] && last_wd == VEC[v][15:0],
          "R3 R11 write", {last_wa, last_wd}, {VEC[v][20:16], VEC[v][15:0]});
      r0 = rd_cyc;
      do_read(VEC[v][23:16], d, ok);
      chk(ok && d == VEC[v][15:0], "R5 read data", d, VEC[v][15:0]);
      chk(rd_cyc == r0 + 1 && last_ra == VEC[v][20:16], "R6 one read strobe",
          rd_cyc - r0, 1);
    end

    // R2: foreign address is refused and the rest of the transaction ignored
    w0 = wr_cyc; r0 = rd_cyc;
    bus_start;
    send_byte(8'hAE, 1'b0, a);
    chk(!a, "R2 foreign address nack", a, 0);
    send_byte(8'h04, 1'b0, a);
    chk(!a, "R2 ignored byte", a, 0);
    send_byte(8'h55, 1'b0, a); send_byte(8'h66, 1'b0, a);
    bus_stop;
    chk(wr_cyc == w0 && rd_cyc == r0, "R2 no strobes", wr_cyc - w0, 0);

    // R4: stop after one data byte
    w0 = wr_cyc;
    bus_start;
    send_byte(DEVW, 1'b0, a); send_byte(8'h02, 1'b0, a); send_byte(8'h99, 1'b0, a);
    bus_stop;
    chk(wr_cyc == w0, "R4 no write", wr_cyc - w0, 0);
    do_read(8'h02, d, ok);
    chk(d == 16'h0102, "R4 register unchanged", d, 16'h0102);

    // R7: pointer-only write, then read in a separate transaction
    w0 = wr_cyc; r0 = rd_cyc;
    bus_start;
    send_byte(DEVW, 1'b0, a); send_byte(8'h05, 1'b0, a);
    bus_stop;
    bus_start;
    send_byte(DEVR, 1'b0, a);
    recv_byte(1'b1, d[15:8]); recv_byte(1'b0, d[7:0]);
    bus_stop;
    chk(a && d == 16'h0105, "R7 pointer kept", d, 16'h0105);
    chk(wr_cyc == w0 && last_ra == 5'd5, "R7 no write strobe", wr_cyc - w0, 0);

    // R8: third data byte refused
    w0 = wr_cyc;
    bus_start;
    send_byte(DEVW, 1'b0, a); send_byte(8'h09, 1'b0, a);
    send_byte(8'h4D, 1'b0, a); send_byte(8'h2A, 1'b0, a);
    send_byte(8'h77, 1'b0, a);
    chk(!a, "R8 extra byte nack", a, 0);
    bus_stop;
    chk(wr_cyc == w0 + 1 && last_wd == 16'h4D2A, "R8 single write", last_wd, 16'h4D2A);
    do_read(8'h09, d, ok);
    chk(d == 16'h4D2A, "R8 readback", d, 16'h4D2A);

    // R9: short pulses on both lines during a write
    w0 = wr_cyc;
    do_write(8'h14, 16'hC35A, 1'b1, ok);
    chk(ok && wr_cyc == w0 + 1 && last_wa == 5'd20 && last_wd == 16'hC35A,
        "R9 glitch write", last_wd, 16'hC35A);
    do_read(8'h14, d, ok);
    chk(d == 16'hC35A, "R9 readback", d, 16'hC35A);

    // R10: strobes never overlap
    chk(both_cyc == 0, "R10 no overlap", both_cyc, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule